// File: doc/BRIEF.md
# Prioritized Scratchpad Port Arbiter

This block puts one single-ported scratchpad memory in front of three clients: a DMA engine, a processor load/store unit (LSU) and an instruction prefetcher. In each cycle it grants the port to at most one of them, using a fixed priority. The grant is combinational on the cycle's requests. The memory action happens at the clock edge that closes the grant cycle.

The DMA client works on whole lines of `LINE_QW` quadwords: 8 × 16 bytes = 128 bytes by default. A DMA read returns the full line one cycle after the grant. A DMA write carries one enable bit per quadword, so it can update part of a line. The LSU and the prefetcher work on single 16-byte quadwords. Their read data comes back after a fixed load latency of `LOAD_LAT` cycles.

The prefetcher has the lowest priority, so it can be starved. A saturating counter counts its consecutive denied cycles and raises a starvation flag when the count reaches a configurable limit. Any requester that is not granted must keep its request and operands stable until it is granted.

Top module: `spad_port_arb`

## Requirements
- R1: At most one of `dma_gnt`, `lsu_gnt`, `pf_gnt` is high in any cycle. A request is granted in the same cycle it is raised if no higher-priority request is present.
- R2: Priority is fixed: DMA first, then LSU, then prefetch. A lower-priority request is denied while any higher-priority request is high.
- R3: A granted DMA read (`dma_we`=0) raises `dma_rvalid` for one cycle, in the cycle after the grant. `dma_rdata` then holds the line selected by `dma_addr[11:7]`. Quadword j of the line is at bits [128j+127:128j]. Address bits [6:0] are ignored.
- R4: A granted DMA write writes quadword j of the addressed line only when `dma_qw_en[j]` is 1. Quadwords whose enable bit is 0 keep their old contents.
- R5: A granted LSU write (`lsu_we`=1) stores `lsu_wdata` in the quadword selected by `lsu_addr[11:4]`. Address bits [3:0] are ignored.
- R6: A granted LSU read raises `lsu_rvalid` for exactly one cycle, exactly `LOAD_LAT` (6) cycles after the grant cycle. `lsu_rdata` then holds the addressed quadword. Neither write kind raises any rvalid.
- R7: A granted prefetch read returns its quadword on `pf_rdata`/`pf_rvalid` with the same `LOAD_LAT` latency. `lsu_rvalid` and `pf_rvalid` are never high together.
- R8: `pf_starved` rises after `STARVE_LIMIT` (8) consecutive cycles in which `pf_req` is high and `pf_gnt` is low. It stays high while the denials continue. It is low in the cycle after a prefetch grant, and in the cycle after `pf_req` drops.
- R9: After reset, `dma_rvalid`, `lsu_rvalid`, `pf_rvalid` and `pf_starved` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | DMA line access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 12 | DMA byte address, line aligned |
| dma_qw_en | input | 8 | Per-quadword write enables |
| dma_wdata | input | 1024 | DMA line write data |
| dma_gnt | output | 1 | DMA granted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 1024 | DMA line read data |
| lsu_req | input | 1 | LSU quadword request |
| lsu_we | input | 1 | LSU write (1) or read (0) |
| lsu_addr | input | 12 | LSU byte address, quadword aligned |
| lsu_wdata | input | 128 | LSU write data |
| lsu_gnt | output | 1 | LSU granted this cycle |
| lsu_rvalid | output | 1 | LSU load data valid |
| lsu_rdata | output | 128 | LSU load data |
| pf_req | input | 1 | Prefetch read request |
| pf_addr | input | 12 | Prefetch byte address, quadword aligned |
| pf_gnt | output | 1 | Prefetch granted this cycle |
| pf_rvalid | output | 1 | Prefetch data valid |
| pf_rdata | output | 128 | Prefetch data |
| pf_starved | output | 1 | Prefetcher starvation flag |

## Verification
The bench raises all three requests in one cycle and then removes them one at a time. An arbiter with the wrong order would grant the LSU or the prefetcher ahead of DMA, and a missing grant exclusion would show two grants at once.

A DMA write with a checkerboard enable mask catches a design that ignores the enables: that design would overwrite the odd quadwords. Wide and narrow reads use unaligned low address bits, so a design that decodes those bits returns the wrong line or quadword.

LSU and prefetch reads are timed cycle by cycle. An off-by-one pipeline length moves the valid pulse, and a shared return path that mixes up sources raises the wrong valid. The starvation flag is checked one cycle before the limit and at the limit. It is also checked after both ways of clearing it, so a counter off by one or one that never resets would be seen.

// File: rtl/spad_pkg.sv
package spad_pkg;
    localparam int QW_BITS  = 128;
    localparam int QW_BYTES = QW_BITS / 8;
    localparam int QW_OFF_W = $clog2(QW_BYTES);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DMA  = 2'd1,
        SRC_LSU  = 2'd2,
        SRC_PF   = 2'd3
    } src_e;

    typedef struct packed {
        logic               valid;
        logic               to_pf;
        logic [QW_BITS-1:0] data;
    } nrd_t;
endpackage

// File: rtl/spad_prio_arb.sv
module spad_prio_arb
    import spad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_req,
    input  logic lsu_req,
    input  logic pf_req,
    output logic dma_gnt,
    output logic lsu_gnt,
    output logic pf_gnt,
    output src_e src
);
    always_comb begin
        dma_gnt = 1'b0;
        lsu_gnt = 1'b0;
        pf_gnt  = 1'b0;
        src     = SRC_NONE;
        if (dma_req) begin
            dma_gnt = 1'b1;
            src     = SRC_DMA;
        end else if (lsu_req) begin
            lsu_gnt = 1'b1;
            src     = SRC_LSU;
        end else if (pf_req) begin
            pf_gnt = 1'b1;
            src    = SRC_PF;
        end
    end

    // R1: single port, single grant
    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_gnt, lsu_gnt, pf_gnt}));
    // R2: DMA outranks the others
    a_r2_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (!lsu_gnt && !pf_gnt));
    // R2: LSU outranks prefetch
    a_r2_lsu_over_pf: assert property (@(posedge clk) disable iff (!rst_n)
        (lsu_req && !dma_req) |-> (lsu_gnt && !pf_gnt));
endmodule

// File: rtl/spad_mem_array.sv
module spad_mem_array
    import spad_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int LINE_QW   = 8,
    localparam int LINE_IDX_W = $clog2(NUM_LINES),
    localparam int QW_SEL_W   = $clog2(LINE_QW),
    localparam int QW_IDX_W   = LINE_IDX_W + QW_SEL_W,
    localparam int NUM_QW     = NUM_LINES * LINE_QW,
    localparam int LINE_BITS  = LINE_QW * QW_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  src_e                  src,
    input  logic                  dma_we,
    input  logic [LINE_IDX_W-1:0] dma_line,
    input  logic [LINE_QW-1:0]    dma_qw_en,
    input  logic [LINE_BITS-1:0]  dma_wdata,
    input  logic                  lsu_we,
    input  logic [QW_IDX_W-1:0]   n_qw,
    input  logic [QW_BITS-1:0]    n_wdata,
    output logic                  line_rvalid,
    output logic [LINE_BITS-1:0]  line_rdata,
    output nrd_t                  nrd
);
    typedef struct packed {
        logic                 line_valid;
        logic [LINE_BITS-1:0] line_data;
        nrd_t                 nrd;
    } rd_st_t;

    logic [QW_BITS-1:0] mem_q [NUM_QW];
    rd_st_t rd_d, rd_q;

    // Storage array: kept out of the registered struct because of its size
    always_ff @(posedge clk) begin
        if (src == SRC_DMA && dma_we) begin
            for (int j = 0; j < LINE_QW; j++) begin
                if (dma_qw_en[j]) begin
                    mem_q[{dma_line, QW_SEL_W'(j)}] <= dma_wdata[j*QW_BITS +: QW_BITS];
                end
            end
        end else if (src == SRC_LSU && lsu_we) begin
            mem_q[n_qw] <= n_wdata;
        end
    end

    always_comb begin
        rd_d            = rd_q;
        rd_d.line_valid = (src == SRC_DMA) && !dma_we;
        if (rd_d.line_valid) begin
            for (int j = 0; j < LINE_QW; j++) begin
                rd_d.line_data[j*QW_BITS +: QW_BITS] = mem_q[{dma_line, QW_SEL_W'(j)}];
            end
        end
        rd_d.nrd.valid = ((src == SRC_LSU) && !lsu_we) || (src == SRC_PF);
        rd_d.nrd.to_pf = (src == SRC_PF);
        if (rd_d.nrd.valid) begin
            rd_d.nrd.data = mem_q[n_qw];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign line_rvalid = rd_q.line_valid;
    assign line_rdata  = rd_q.line_data;
    assign nrd         = rd_q.nrd;
endmodule

// File: rtl/spad_rd_pipe.sv
module spad_rd_pipe
    import spad_pkg::*;
#(
    parameter int STAGES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  nrd_t din,
    output nrd_t dout
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_shift
            typedef struct packed {
                nrd_t [STAGES-1:0] stg;
            } pipe_st_t;
            pipe_st_t st_d, st_q;

            always_comb begin
                st_d        = st_q;
                st_d.stg[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    st_d.stg[i] = st_q.stg[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign dout = st_q.stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spad_starve_mon.sv
module spad_starve_mon #(
    parameter int LIMIT = 8,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_req,
    input  logic pf_gnt,
    output logic starved
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } mon_st_t;
    mon_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pf_req && !pf_gnt) begin
            if (st_q.cnt != CNT_W'(LIMIT)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign starved = (st_q.cnt == CNT_W'(LIMIT));

    // R8: flag holds through continued denial
    a_r8_starve_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (starved && pf_req && !pf_gnt) |=> starved);
    // R8: a grant clears the flag
    a_r8_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pf_gnt |=> !starved);
endmodule

// File: rtl/spad_port_arb.sv
module spad_port_arb
    import spad_pkg::*;
#(
    parameter int NUM_LINES    = 32,
    parameter int LINE_QW      = 8,
    parameter int LOAD_LAT     = 6,
    parameter int STARVE_LIMIT = 8,
    localparam int LINE_IDX_W = $clog2(NUM_LINES),
    localparam int QW_SEL_W   = $clog2(LINE_QW),
    localparam int QW_IDX_W   = LINE_IDX_W + QW_SEL_W,
    localparam int ADDR_W     = QW_IDX_W + QW_OFF_W,
    localparam int LINE_BITS  = LINE_QW * QW_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dma_req,
    input  logic                 dma_we,
    input  logic [ADDR_W-1:0]    dma_addr,
    input  logic [LINE_QW-1:0]   dma_qw_en,
    input  logic [LINE_BITS-1:0] dma_wdata,
    output logic                 dma_gnt,
    output logic                 dma_rvalid,
    output logic [LINE_BITS-1:0] dma_rdata,
    input  logic                 lsu_req,
    input  logic                 lsu_we,
    input  logic [ADDR_W-1:0]    lsu_addr,
    input  logic [QW_BITS-1:0]   lsu_wdata,
    output logic                 lsu_gnt,
    output logic                 lsu_rvalid,
    output logic [QW_BITS-1:0]   lsu_rdata,
    input  logic                 pf_req,
    input  logic [ADDR_W-1:0]    pf_addr,
    output logic                 pf_gnt,
    output logic                 pf_rvalid,
    output logic [QW_BITS-1:0]   pf_rdata,
    output logic                 pf_starved
);
    localparam int PIPE_STAGES = LOAD_LAT - 1;

    src_e                  src;
    logic [QW_IDX_W-1:0]   n_qw;
    nrd_t                  mem_nrd, ret_nrd;
    logic                  unused_low_bits;

    assign unused_low_bits = ^{dma_addr[ADDR_W-LINE_IDX_W-1:0],
                               lsu_addr[QW_OFF_W-1:0], pf_addr[QW_OFF_W-1:0]};

    spad_prio_arb i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .dma_req (dma_req),
        .lsu_req (lsu_req),
        .pf_req  (pf_req),
        .dma_gnt (dma_gnt),
        .lsu_gnt (lsu_gnt),
        .pf_gnt  (pf_gnt),
        .src     (src)
    );

    assign n_qw = (src == SRC_PF) ? pf_addr[ADDR_W-1:QW_OFF_W] : lsu_addr[ADDR_W-1:QW_OFF_W];

    spad_mem_array #(.NUM_LINES(NUM_LINES), .LINE_QW(LINE_QW)) i_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (src),
        .dma_we      (dma_we),
        .dma_line    (dma_addr[ADDR_W-1 -: LINE_IDX_W]),
        .dma_qw_en   (dma_qw_en),
        .dma_wdata   (dma_wdata),
        .lsu_we      (lsu_we),
        .n_qw        (n_qw),
        .n_wdata     (lsu_wdata),
        .line_rvalid (dma_rvalid),
        .line_rdata  (dma_rdata),
        .nrd         (mem_nrd)
    );

    spad_rd_pipe #(.STAGES(PIPE_STAGES)) i_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mem_nrd),
        .dout  (ret_nrd)
    );

    assign lsu_rvalid = ret_nrd.valid && !ret_nrd.to_pf;
    assign pf_rvalid  = ret_nrd.valid && ret_nrd.to_pf;
    assign lsu_rdata  = ret_nrd.data;
    assign pf_rdata   = ret_nrd.data;

    spad_starve_mon #(.LIMIT(STARVE_LIMIT)) i_starve (
        .clk     (clk),
        .rst_n   (rst_n),
        .pf_req  (pf_req),
        .pf_gnt  (pf_gnt),
        .starved (pf_starved)
    );

    // R3: a line read answers in the next cycle
    a_r3_line_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && !dma_we) |=> dma_rvalid);
    // R3: no line data without a line read
    a_r3_no_spurious_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_gnt && !dma_we) |=> !dma_rvalid);
    // R7: one narrow return per cycle
    a_r7_return_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lsu_rvalid && pf_rvalid));
endmodule

// File: tb/test_spad_port_arb.sv
module test_spad_port_arb;
    localparam int LAT   = 6;
    localparam int LIMIT = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dma_req = 0, dma_we = 0;
    logic [11:0]    dma_addr = '0;
    logic [7:0]     dma_qw_en = '0;
    logic [1023:0]  dma_wdata = '0;
    logic           dma_gnt, dma_rvalid;
    logic [1023:0]  dma_rdata;
    logic           lsu_req = 0, lsu_we = 0;
    logic [11:0]    lsu_addr = '0;
    logic [127:0]   lsu_wdata = '0;
    logic           lsu_gnt, lsu_rvalid;
    logic [127:0]   lsu_rdata;
    logic           pf_req = 0;
    logic [11:0]    pf_addr = '0;
    logic           pf_gnt, pf_rvalid;
    logic [127:0]   pf_rdata;
    logic           pf_starved;

    logic [127:0] shadow [256];
    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    spad_port_arb i_spad_port_arb (.*);

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
            summary();
        end
    end

    task automatic chk(string req, logic [1023:0] act, logic [1023:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(int a, int s);
        return {32'(s), 32'(a), ~32'(s), 32'(a * 7 + s)};
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        dma_req = 0; lsu_req = 0; pf_req = 0; dma_we = 0; lsu_we = 0;
    endtask

    task automatic t_reset();
        chk("R9 dma_rvalid", 1024'(dma_rvalid), 0);
        chk("R9 lsu_rvalid", 1024'(lsu_rvalid), 0);
        chk("R9 pf_rvalid", 1024'(pf_rvalid), 0);
        chk("R9 pf_starved", 1024'(pf_starved), 0);
        chk("R1 no grant idle", 1024'({dma_gnt, lsu_gnt, pf_gnt}), 0);
    endtask

    task automatic t_wide_write(int line, logic [7:0] en, int seed);
        dma_req = 1; dma_we = 1; dma_addr = {5'(line), 7'h00}; dma_qw_en = en;
        for (int j = 0; j < 8; j++) dma_wdata[j*128 +: 128] = pat(line * 8 + j, seed);
        #1 chk("R1 dma write grant", 1024'(dma_gnt), 1);
        cyc();
        for (int j = 0; j < 8; j++) if (en[j]) shadow[line*8+j] = pat(line * 8 + j, seed);
        idle();
        chk("R6 no rvalid after write", 1024'({dma_rvalid, lsu_rvalid}), 0);
    endtask

    task automatic t_wide_read(int line, logic [6:0] low, string req);
        logic [1023:0] exp;
        for (int j = 0; j < 8; j++) exp[j*128 +: 128] = shadow[line*8+j];
        dma_req = 1; dma_we = 0; dma_addr = {5'(line), low};
        #1 chk("R1 dma read grant", 1024'(dma_gnt), 1);
        cyc();
        idle();
        chk({req, " rvalid"}, 1024'(dma_rvalid), 1);
        chk({req, " line data"}, dma_rdata, exp);
        cyc();
        chk("R3 rvalid single", 1024'(dma_rvalid), 0);
    endtask

    task automatic t_lsu_write(int qw, logic [3:0] low, int seed);
        lsu_req = 1; lsu_we = 1; lsu_addr = {8'(qw), low}; lsu_wdata = pat(qw, seed);
        #1 chk("R1 lsu write grant", 1024'(lsu_gnt), 1);
        cyc();
        shadow[qw] = pat(qw, seed);
        idle();
    endtask

    task automatic t_lsu_read(int qw, logic [3:0] low);
        lsu_req = 1; lsu_we = 0; lsu_addr = {8'(qw), low};
        #1 chk("R1 lsu read grant", 1024'(lsu_gnt), 1);
        for (int k = 1; k <= LAT; k++) begin
            cyc();
            idle();
            chk($sformatf("R6 lsu_rvalid at +%0d", k), 1024'(lsu_rvalid), 1024'(k == LAT));
        end
        chk("R5 R6 lsu data", 1024'(lsu_rdata), 1024'(shadow[qw]));
        cyc();
        chk("R6 lsu_rvalid one cycle", 1024'(lsu_rvalid), 0);
    endtask

    task automatic t_priority();
        dma_req = 1; dma_we = 0; dma_addr = 12'h000;
        lsu_req = 1; lsu_we = 0; lsu_addr = {8'd17, 4'h0};
        pf_req = 1; pf_addr = {8'd42, 4'h9};
        #1 chk("R2 all request", 1024'({dma_gnt, lsu_gnt, pf_gnt}), 1024'(3'b100));
        cyc();
        dma_req = 0;
        #1 chk("R2 lsu over pf", 1024'({dma_gnt, lsu_gnt, pf_gnt}), 1024'(3'b010));
        cyc();
        lsu_req = 0;
        #1 chk("R2 pf last", 1024'({dma_gnt, lsu_gnt, pf_gnt}), 1024'(3'b001));
        cyc();
        pf_req = 0;
        for (int k = 0; k < LAT - 2; k++) cyc();
        chk("R7 lsu returns first", 1024'({lsu_rvalid, pf_rvalid}), 1024'(2'b10));
        chk("R6 lsu data", 1024'(lsu_rdata), 1024'(shadow[17]));
        cyc();
        chk("R7 pf returns next", 1024'({lsu_rvalid, pf_rvalid}), 1024'(2'b01));
        chk("R7 pf data", 1024'(pf_rdata), 1024'(shadow[42]));
        cyc();
        chk("R7 pf_rvalid one cycle", 1024'(pf_rvalid), 0);
    endtask

    task automatic t_starve(bit clear_by_grant);
        lsu_req = 1; lsu_we = 0; lsu_addr = 12'h010;
        pf_req = 1; pf_addr = 12'h020;
        for (int k = 1; k <= LIMIT; k++) begin
            cyc();
            if (k >= LIMIT - 1)
                chk($sformatf("R8 starved after %0d denials", k), 1024'(pf_starved), 1024'(k == LIMIT));
        end
        cyc();
        chk("R8 starved holds", 1024'(pf_starved), 1);
        if (clear_by_grant) begin
            lsu_req = 0;
            #1 chk("R2 pf granted when alone", 1024'(pf_gnt), 1);
            cyc();
            chk("R8 cleared by grant", 1024'(pf_starved), 0);
        end else begin
            pf_req = 0;
            cyc();
            chk("R8 cleared by drop", 1024'(pf_starved), 0);
        end
        idle();
        for (int k = 0; k < LAT + 1; k++) cyc();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        for (int l = 0; l < 32; l++) t_wide_write(l, 8'hFF, 0);
        t_wide_write(2, 8'hFF, 100);
        t_wide_read(2, 7'h5A, "R3");
        t_wide_write(2, 8'b0101_0101, 200);
        t_wide_read(2, 7'h00, "R4");
        t_wide_write(31, 8'b1000_0001, 300);
        t_wide_read(31, 7'h7F, "R4");
        t_lsu_write(8'h23, 4'hF, 400);
        t_lsu_read(8'h23, 4'h7);
        t_lsu_read(8'h10, 4'h0);
        t_wide_read(4, 7'h11, "R5 narrow write seen wide");
        t_priority();
        t_starve(1'b1);
        t_starve(1'b0);
        summary();
    end
endmodule